// File: doc/BRIEF.md
# Baud Rate and Clock-Out Generator

This block is the alternate running mode of a 16-bit reloadable timer. It becomes active when either serial clock-select input is high or when the clock-out enable is high. While it is active and running, the counter advances once every two oscillator cycles, or once per falling edge on an external count pin when pin-count mode is chosen. Each time it rolls over from all ones, it reloads from a 16-bit reload value. One counter serves two purposes at once. Its rollovers are divided by 16 to give the receive and transmit serial ticks. They also toggle a square-wave clock-out pin.

Each serial direction picks its own source. It uses either this counter's rollovers or an external overflow pulse from another timer. That external pulse is halved first unless the double-rate input is high. A rollover in this mode never raises an overflow flag. With the trigger enable set, a falling edge on the trigger pin sets a sticky flag and does not reload the counter. While the run input is low, the counter is held at the reload value, so the first period after a start has full length. The serial receiver and transmitter are outside this block.

Top module: `baud_clkout_gen`

## Requirements
- R1: After reset, count_val is 0, and rx_tick, tx_tick, clk_out and ext_flag are all 0.
- R2: While run is 0, count_val follows reload_val one cycle later. With run at 1, pin_count_mode at 0 and any of rx_sel, tx_sel or clkout_en at 1, count_val increases by one every second clock cycle. With run at 1 and none of the three select inputs at 1, count_val holds.
- R3: An increment from 16'hFFFF loads reload_val into count_val instead of wrapping to 0.
- R4: With pin_count_mode at 1, count_val increases by one for each 1-to-0 change on count_pin. The change appears three clock edges after it occurs, because the pin passes through a two-flop synchroniser and one further edge-detect flop.
- R5: With rx_sel at 1, rx_tick pulses for one cycle on every 16th rollover. With tx_sel at 1, tx_tick does the same, independently of the receive side. With reload 16'hFFFE in state-rate mode, ticks are 64 cycles apart.
- R6: A direction whose select input is 0 counts t1_ovf pulses instead. It ticks once per 32 pulses when smod is 0 and once per 16 pulses when smod is 1.
- R7: When clkout_en is 1 and pin_count_mode is 0, clk_out toggles on each rollover. With reload 16'hFFFE this gives a 4-cycle half period. In every other case clk_out is held at 0.
- R8: When ext_en is 1 and the mode is active, a falling edge on trig_pin sets ext_flag three edges later and leaves count_val as it would otherwise be. When ext_en is 0, such an edge has no effect on ext_flag.
- R9: ext_flag stays at 1 until a cycle with flag_clr at 1 clears it. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sel | input | 1 | Receive tick uses this counter's rollovers (1) or t1_ovf (0) |
| tx_sel | input | 1 | Transmit tick uses this counter's rollovers (1) or t1_ovf (0) |
| clkout_en | input | 1 | Enables the square-wave clock-out |
| pin_count_mode | input | 1 | 1: count count_pin falling edges; 0: count every second oscillator cycle |
| run | input | 1 | Start (1) or stop (0) the counter |
| reload_val | input | 16 | Reload value used on rollover and while stopped |
| ext_en | input | 1 | Lets trig_pin falling edges set ext_flag |
| t1_ovf | input | 1 | One-cycle overflow pulse from the other timer |
| smod | input | 1 | 1: t1_ovf is not halved before the divide-by-16 stage |
| count_pin | input | 1 | External count input |
| trig_pin | input | 1 | External trigger input |
| flag_clr | input | 1 | Clears ext_flag |
| count_val | output | 16 | Current counter value |
| rx_tick | output | 1 | Receive serial tick, one cycle wide |
| tx_tick | output | 1 | Transmit serial tick, one cycle wide |
| clk_out | output | 1 | Square-wave clock-out |
| ext_flag | output | 1 | Sticky trigger flag |

## Verification
The assertions check four behaviours on every cycle. A rollover must load the reload value, and a stopped counter must be preset from it. Ticks must stay one cycle wide, and clk_out must toggle exactly on rollovers and stay low when disabled. ext_flag must set on a trigger and stay set until cleared. Only the bench scenarios can show the rates themselves: 64-cycle tick spacing, the 32- and 16-pulse spacing for the two smod settings, and the 4-cycle clock-out half period. The scenarios are also needed to show the three-edge synchroniser latency and that a trigger edge never disturbs the count.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  typedef enum logic [1:0] {
    ADV_HOLD  = 2'd0,
    ADV_STATE = 2'd1,
    ADV_PIN   = 2'd2
  } adv_e;

  // Which event advances the counter this cycle.
  function automatic adv_e pick_adv(input logic active, input logic run,
                                    input logic pin_mode);
    if (!(active && run)) return ADV_HOLD;
    if (pin_mode)         return ADV_PIN;
    return ADV_STATE;
  endfunction

  // Other-timer overflow after the optional halving stage.
  function automatic logic t1_pass(input logic ovf, input logic smod,
                                   input logic half_ph);
    return ovf && (smod || half_ph);
  endfunction

endpackage

// File: rtl/bclk_sync_fall.sv
module bclk_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  localparam int unsigned TOP = STAGES;

  logic [TOP:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[TOP-1:0], pin};
  end

  assign fall = chain_q[TOP] & ~chain_q[TOP-1];
endmodule

// File: rtl/bclk_core.sv
module bclk_core
  import bclk_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             run,
  input  logic             pin_mode,
  input  logic             pin_fall,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             roll
);
  adv_e       adv;
  logic       phase_q;
  logic       inc;
  logic [CNT_W-1:0] count_q;

  assign adv = pick_adv(active, run, pin_mode);

  always_comb begin
    case (adv)
      ADV_STATE: inc = phase_q;
      ADV_PIN:   inc = pin_fall;
      default:   inc = 1'b0;
    endcase
  end

  assign roll  = inc && (count_q == {CNT_W{1'b1}});
  assign count = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_q <= 1'b0;
    else if (adv == ADV_STATE) phase_q <= ~phase_q;
    else                       phase_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (!run) count_q <= reload;
    else if (inc)  count_q <= roll ? reload : count_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  AST_RELOAD_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> count_q == $past(reload)); // R3
  AST_STOP_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count_q == $past(reload)); // R2
  AST_STATE_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && adv == ADV_STATE) |=> !(inc && adv == ADV_STATE)); // R2
endmodule

// File: rtl/bclk_ser_div.sv
module bclk_ser_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_timer,
  input  logic roll,
  input  logic t1_src,
  output logic tick
);
  logic [DIV_W-1:0] div_q;
  logic             tick_q;
  logic             src;

  assign src = use_timer ? roll : t1_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= src && (div_q == {DIV_W{1'b1}});
      if (src) div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
    end
  end

  assign tick = tick_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R5
endmodule

// File: rtl/baud_clkout_gen.sv
module baud_clkout_gen
  import bclk_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sel,
  input  logic             tx_sel,
  input  logic             clkout_en,
  input  logic             pin_count_mode,
  input  logic             run,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             ext_en,
  input  logic             t1_ovf,
  input  logic             smod,
  input  logic             count_pin,
  input  logic             trig_pin,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_val,
  output logic             rx_tick,
  output logic             tx_tick,
  output logic             clk_out,
  output logic             ext_flag
);
  localparam int unsigned N_DIR = 2;

  logic             active;
  logic             cnt_fall;
  logic             trig_fall;
  logic             roll;
  logic             t1_half_q;
  logic             t1_src;
  logic             co_on;
  logic             co_q;
  logic             trig_set;
  logic             flag_q;
  logic [N_DIR-1:0] dir_sel;
  logic [N_DIR-1:0] dir_tick;

  assign active = rx_sel | tx_sel | clkout_en;

  bclk_sync_fall #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(count_pin), .fall(cnt_fall));

  bclk_sync_fall #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

  bclk_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .active(active), .run(run),
    .pin_mode(pin_count_mode), .pin_fall(cnt_fall), .reload(reload_val),
    .count(count_val), .roll(roll));

  // Shared halving stage for the other timer's overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      t1_half_q <= 1'b0;
    else if (t1_ovf) t1_half_q <= ~t1_half_q;
  end
  assign t1_src = t1_pass(t1_ovf, smod, t1_half_q);

  assign dir_sel = {tx_sel, rx_sel};

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    bclk_ser_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .use_timer(dir_sel[d]), .roll(roll),
      .t1_src(t1_src), .tick(dir_tick[d]));
  end

  assign rx_tick = dir_tick[0];
  assign tx_tick = dir_tick[1];

  // Clock-out toggle
  assign co_on = clkout_en && !pin_count_mode;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     co_q <= 1'b0;
    else if (co_on) co_q <= co_q ^ roll;
    else            co_q <= 1'b0;
  end
  assign clk_out = co_q;

  // Sticky trigger flag, set beats clear
  assign trig_set = ext_en && active && trig_fall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= trig_set | (flag_q & ~flag_clr);
  end
  assign ext_flag = flag_q;

  AST_CLKOUT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (co_on && roll) |=> co_q != $past(co_q)); // R7
  AST_CLKOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !co_on |=> !co_q); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trig_set |=> flag_q); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R9
endmodule

// File: tb/baud_clkout_gen_tb.sv
`timescale 1ns/1ps
module baud_clkout_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_sel = 0, tx_sel = 0, clkout_en = 0, pin_count_mode = 0, run = 0;
  logic [15:0] reload_val = 16'h0000;
  logic ext_en = 0, t1_ovf = 0, smod = 0, count_pin = 1, trig_pin = 1, flag_clr = 0;
  logic [15:0] count_val;
  logic rx_tick, tx_tick, clk_out, ext_flag;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  int t1_period = 0;
  int t1_cnt    = 0;

  always #4 clk = ~clk;

  baud_clkout_gen dut_i (
    .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel), .tx_sel(tx_sel),
    .clkout_en(clkout_en), .pin_count_mode(pin_count_mode), .run(run),
    .reload_val(reload_val), .ext_en(ext_en), .t1_ovf(t1_ovf), .smod(smod),
    .count_pin(count_pin), .trig_pin(trig_pin), .flag_clr(flag_clr),
    .count_val(count_val), .rx_tick(rx_tick), .tx_tick(tx_tick),
    .clk_out(clk_out), .ext_flag(ext_flag));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cnt = 0, m_ph = 0, m_t1h = 0, m_co = 0, m_flag = 0;
  int m_rdiv = 0, m_tdiv = 0, m_rtick = 0, m_ttick = 0;
  int c_hist[3] = '{1, 1, 1};
  int t_hist[3] = '{1, 1, 1};
  bit m_valid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_t1h = 0; m_co = 0; m_flag = 0;
      m_rdiv = 0; m_tdiv = 0; m_rtick = 0; m_ttick = 0;
      c_hist = '{1, 1, 1}; t_hist = '{1, 1, 1};
    end else begin
      bit act, cfall, tfall, inc, rl, t1s, rsrc, tsrc;
      act   = rx_sel || tx_sel || clkout_en;
      cfall = (c_hist[2] == 1) && (c_hist[1] == 0);
      tfall = (t_hist[2] == 1) && (t_hist[1] == 0);
      inc = 0;
      if (run && act && !pin_count_mode) begin
        inc = (m_ph == 1);
        m_ph = 1 - m_ph;
      end else begin
        m_ph = 0;
        if (run && act && pin_count_mode) inc = cfall;
      end
      rl = inc && (m_cnt == 65535);
      if (!run) m_cnt = reload_val;
      else if (inc) m_cnt = rl ? int'(reload_val) : m_cnt + 1;
      t1s = t1_ovf && (smod || m_t1h == 1);
      if (t1_ovf) m_t1h = 1 - m_t1h;
      rsrc = rx_sel ? rl : t1s;
      tsrc = tx_sel ? rl : t1s;
      m_rtick = (rsrc && m_rdiv == 15) ? 1 : 0;
      m_ttick = (tsrc && m_tdiv == 15) ? 1 : 0;
      if (rsrc) m_rdiv = (m_rdiv + 1) % 16;
      if (tsrc) m_tdiv = (m_tdiv + 1) % 16;
      if (clkout_en && !pin_count_mode) m_co = rl ? 1 - m_co : m_co;
      else m_co = 0;
      if (ext_en && act && tfall) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      c_hist[2] = c_hist[1]; c_hist[1] = c_hist[0]; c_hist[0] = count_pin;
      t_hist[2] = t_hist[1]; t_hist[1] = t_hist[0]; t_hist[0] = trig_pin;
    end
    m_valid = 1;
  end

  always @(negedge clk) begin
    if (m_valid) begin
      chk("R2/R3/R4", "count_val", int'(count_val), m_cnt);
      chk("R5/R6", "rx_tick", int'(rx_tick), m_rtick);
      chk("R5/R6", "tx_tick", int'(tx_tick), m_ttick);
      chk("R7", "clk_out", int'(clk_out), m_co);
      chk("R8/R9", "ext_flag", int'(ext_flag), m_flag);
    end
  end

  // other-timer overflow pulse generator
  always @(negedge clk) begin
    if (t1_period > 0) begin
      t1_cnt = (t1_cnt + 1) % t1_period;
      t1_ovf <= (t1_cnt == 0);
    end else begin
      t1_ovf <= 1'b0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic tick_of(input int w);
    return (w == 0) ? rx_tick : tx_tick;
  endfunction

  task automatic tick_gap(input int w, output int g);
    while (!tick_of(w)) @(negedge clk);
    @(negedge clk);
    g = 1;
    while (!tick_of(w)) begin @(negedge clk); g++; end
  endtask

  task automatic clkout_half(output int g);
    logic v;
    v = clk_out;
    while (clk_out == v) @(negedge clk);
    v = clk_out;
    @(negedge clk);
    g = 1;
    while (clk_out == v) begin @(negedge clk); g++; end
  endtask

  initial begin
    int g;
    int c0;
    idle(3);
    // R1 reset values
    chk("R1", "count_val", int'(count_val), 0);
    chk("R1", "rx_tick", int'(rx_tick), 0);
    chk("R1", "tx_tick", int'(tx_tick), 0);
    chk("R1", "clk_out", int'(clk_out), 0);
    chk("R1", "ext_flag", int'(ext_flag), 0);
    rst_n = 1'b1;
    idle(2);

    // R2: stopped counter follows reload
    reload_val = 16'hFFFE;
    idle(2);
    chk("R2", "preset while stopped", int'(count_val), 16'hFFFE);

    // R5 / R7: state-rate baud and clock-out
    rx_sel = 1; tx_sel = 1; clkout_en = 1; run = 1;
    tick_gap(0, g); chk("R5", "rx tick gap", g, 64);
    tick_gap(1, g); chk("R5", "tx tick gap", g, 64);
    clkout_half(g); chk("R7", "clk_out half period", g, 4);

    // R3: reload on rollover with a longer period
    run = 0; reload_val = 16'hFFF8; idle(2);
    run = 1;
    while (count_val != 16'hFFFF) @(negedge clk);
    idle(2);
    chk("R3", "value after rollover", int'(count_val), 16'hFFF8);

    // R6: receive from the other timer, halved then not halved
    run = 0; reload_val = 16'hFFFE; idle(2);
    rx_sel = 0; smod = 0; t1_period = 3; run = 1;
    tick_gap(0, g); chk("R6", "rx gap smod=0", g, 96);
    tick_gap(1, g); chk("R5", "tx gap kept", g, 64);
    smod = 1;
    tick_gap(0, g);
    tick_gap(0, g); chk("R6", "rx gap smod=1", g, 48);
    t1_period = 0; smod = 0;

    // R2: no mode bit set holds the count
    rx_sel = 0; tx_sel = 0; clkout_en = 0; idle(2);
    c0 = int'(count_val);
    idle(10);
    chk("R2", "count held with mode off", int'(count_val), c0);
    chk("R7", "clk_out low with mode off", int'(clk_out), 0);

    // R4: pin-count mode
    run = 0; reload_val = 16'h1234; pin_count_mode = 1; clkout_en = 1; idle(2);
    run = 1;
    for (int k = 0; k < 5; k++) begin
      count_pin = 0; idle(3);
      count_pin = 1; idle(3);
    end
    idle(4);
    chk("R4", "five falling edges", int'(count_val), 16'h1239);
    chk("R7", "clk_out low in pin mode", int'(clk_out), 0);

    // R8: trigger sets flag without reload
    run = 0; reload_val = 16'h8000; pin_count_mode = 0; rx_sel = 1; idle(2);
    run = 1; ext_en = 1; idle(3);
    trig_pin = 0; idle(4); trig_pin = 1;
    chk("R8", "flag set by trigger", int'(ext_flag), 1);
    chk("R8", "count not reloaded", int'(count_val != 16'h8000), 1);
    idle(6);
    chk("R9", "flag sticky", int'(ext_flag), 1);
    flag_clr = 1; idle(1); flag_clr = 0; idle(1);
    chk("R9", "flag cleared", int'(ext_flag), 0);
    ext_en = 0;
    trig_pin = 0; idle(5); trig_pin = 1; idle(3);
    chk("R8", "flag ignores edge when disabled", int'(ext_flag), 0);

    // R9: set beats clear in the same cycle
    ext_en = 1; flag_clr = 1;
    trig_pin = 0; idle(8); trig_pin = 1;
    flag_clr = 0; idle(2);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule